// File: doc/BRIEF.md
# Three-Digit Decimal Event Counter

A synchronous decimal counter that holds a value from 000 to 999 as three packed BCD digits. Each one-cycle assertion of the count input advances the value by one. After 999 the value returns to 000. Each digit is four state bits weighted 1, 2, 4 and 8. Each bit is held in a JK-style cell.

A bit changes only when a lower-order bit of the same digit falls from 1 to 0. The set, clear, toggle or hold action comes from that cell's J and K terms. A digit falling from 9 to 0 passes one count event to the next digit up. All of these events are resolved combinationally before the single clock edge. The outputs therefore move straight from one count to the next and never show a partial state. A terminal flag marks the cycle in which a count pulse arrives while the value reads 999.

Top module: `bcd_chain_counter`

## Requirements
- R1: Each digit (bits [3:0] units, [7:4] tens, [11:8] hundreds of `bcd_o`, bit 0 of each digit weight 1 and bit 3 weight 8) only takes values 0..9. Each count event it receives moves it to the next value, and 9 moves to 0.
- R2: The weight-1 bit of a digit inverts on every count event given to that digit.
- R3: The weight-2 bit inverts when the weight-1 bit falls while the weight-8 bit is 0. It is 0 whenever the weight-8 bit is 1.
- R4: The weight-8 bit goes to 1 when the digit steps from 7 to 8. It is cleared by the next fall of the weight-1 bit, which is the step from 9 to 0.
- R5: A digit falling from 9 to 0 advances the next higher digit in the same clock edge. The registered value read one cycle after a pulse is always the full decimal successor.
- R6: With `count_i` low at a clock edge, `bcd_o` does not change.
- R7: While `rst_ni` is low, every digit is 0. Reset is asynchronous.
- R8: `tc_o` is high exactly when `bcd_o` reads 999 and `count_i` is high. The value after that edge is 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 1 | Count pulse, one event per high cycle |
| bcd_o | output | 12 | Three BCD digits, units in the low nibble |
| tc_o | output | 1 | Terminal count: value 999 with a pulse present |

## Verification
Random pulse trains with roughly 70 % duty run the value through all thousand states several times. Idle gaps separate the pulses, so holding and advancing can be told apart. Every sample is compared against a decimal integer model. Separate comparisons on the units bits 0, 1 and 3 show whether an error lies in the weight-1, weight-2 or weight-8 rule. Comparisons on the upper digits show whether an error lies in the carry chain. A long idle stretch, a reset asserted mid-count and a back-to-back pulse burst across 999 isolate holding, reset and wrap with the terminal flag.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // JK action on a trigger: set, clear, toggle or hold
  function automatic logic jk_next(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      2'b11:   return ~q;
      default: return q;
    endcase
  endfunction
endpackage

// File: rtl/bcd_jk_cell.sv
module bcd_jk_cell
  import bcd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic j_i,
  input  logic k_i,
  output logic q_o,
  output logic q_next_o
);
  logic q_q;

  always_comb q_next_o = trig_i ? jk_next(q_q, j_i, k_i) : q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_next_o;
  end

  assign q_o = q_q;
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pulse_i,
  output digit_t digit_o,
  output logic   carry_o
);
  logic q1, q2, q4, q8;
  logic n1, n2, n4, n8;
  logic fall1, fall2;

  bcd_jk_cell u_b1 (
    .clk_i, .rst_ni, .trig_i(pulse_i), .j_i(1'b1), .k_i(1'b1),
    .q_o(q1), .q_next_o(n1)
  );

  assign fall1 = q1 & ~n1;

  // weight 2 frozen while weight 8 is set
  bcd_jk_cell u_b2 (
    .clk_i, .rst_ni, .trig_i(fall1), .j_i(~q8), .k_i(~q8),
    .q_o(q2), .q_next_o(n2)
  );

  assign fall2 = q2 & ~n2;

  bcd_jk_cell u_b4 (
    .clk_i, .rst_ni, .trig_i(fall2), .j_i(1'b1), .k_i(1'b1),
    .q_o(q4), .q_next_o(n4)
  );

  // set only from 7, otherwise cleared on weight-1 fall
  bcd_jk_cell u_b8 (
    .clk_i, .rst_ni, .trig_i(fall1), .j_i(q2 & q4), .k_i(1'b1),
    .q_o(q8), .q_next_o(n8)
  );

  assign digit_o = {q8, q4, q2, q1};
  assign carry_o = q8 & ~n8;

  AST_DIGIT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_o <= digit_t'(MAX_DIGIT)); // R1
  AST_LSB_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> digit_o[0] != $past(digit_o[0])); // R2
  AST_TWO_LOW_WITH_EIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_o[3] |-> !digit_o[1]); // R3
  AST_NINE_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && digit_o == digit_t'(MAX_DIGIT)) |=> digit_o == '0); // R4
  AST_CARRY_AT_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (pulse_i && digit_o == digit_t'(MAX_DIGIT))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(digit_o)); // R6
endmodule

// File: rtl/bcd_chain_counter.sv
module bcd_chain_counter
  import bcd_pkg::*;
#(
  parameter int NUM_DEC = 3,
  localparam int OUT_W  = NUM_DEC * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_i,
  output logic [OUT_W-1:0] bcd_o,
  output logic             tc_o
);
  logic [NUM_DEC:0] chain;

  assign chain[0] = count_i;

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    digit_t dig;
    bcd_decade u_dec (
      .clk_i,
      .rst_ni,
      .pulse_i (chain[g]),
      .digit_o (dig),
      .carry_o (chain[g+1])
    );
    assign bcd_o[g*DIGIT_W +: DIGIT_W] = dig;
  end

  assign tc_o = chain[NUM_DEC];

  AST_TC_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> count_i); // R8
  AST_TC_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> bcd_o == '0); // R8
  AST_HOLD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_i |=> $stable(bcd_o)); // R6
endmodule

// File: tb/bcd_chain_counter_tb_top.sv
`timescale 1ns/1ps
module bcd_chain_counter_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        count_i = 1'b0;
  logic [11:0] bcd_o;
  logic        tc_o;

  int n_run = 0;
  int n_fail = 0;
  int model = 0;
  int wraps = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_chain_counter dut_i (.clk_i, .rst_ni, .count_i, .bcd_o, .tc_o);

  function automatic logic [11:0] to_bcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d (model=%0d)", req, act, exp, model);
    end
  endtask

  task automatic check_value();
    logic [11:0] e = to_bcd(model);
    chk("R2", int'(bcd_o[0]), int'(e[0]));
    chk("R3", int'(bcd_o[1]), int'(e[1]));
    chk("R4", int'(bcd_o[3]), int'(e[3]));
    chk("R5", int'(bcd_o[11:4]), int'(e[11:4]));
    chk("R1", int'(bcd_o), int'(e));
  endtask

  // drive at negedge, check flag, then advance model at the edge
  task automatic step(input logic p);
    @(negedge clk_i);
    check_value();
    count_i = p;
    #1;
    chk("R8", int'(tc_o), int'(model == 999 && p));
    @(posedge clk_i);
    if (p) begin
      if (model == 999) wraps++;
      model = (model + 1) % 1000;
    end
  endtask

  initial begin
    int unsigned seed = 32'd4711;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R7", int'(bcd_o), 0);
    chk("R8", int'(tc_o), 0);
    rst_ni = 1'b1;

    // R2 R3 R4: first digit walk with back-to-back pulses
    for (int i = 0; i < 12; i++) step(1'b1);

    // R6: long idle stretch
    for (int i = 0; i < 20; i++) step(1'b0);

    // R1 R5 R8: random pulses over several full laps
    for (int i = 0; i < 4000; i++) step(($urandom % 10) < 7);

    // R7: asynchronous reset mid-count
    while (model == 0) step(1'b1);
    @(negedge clk_i);
    count_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R7", int'(bcd_o), 0);
    model = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: burst across 999
    while (model != 995) step(1'b1);
    for (int i = 0; i < 8; i++) step(1'b1);
    step(1'b0);
    chk("R8", int'(wraps > 0), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule